// File: doc/BRIEF.md
# Transmit Byte Compare-Replace Filter

This block sits in the transmit path between a byte FIFO and a serial transmitter. Every outgoing byte is tested against two programmable match values, A and B. A byte that hits an enabled match can be deleted from the stream, swapped for a single substitute byte, or expanded into a programmed pair of bytes. Bytes that hit nothing leave unchanged after a single register stage.

Both streams are byte-wide valid/ready handshakes. A write-only configuration port holds the two match values, the three replacement bytes and a five-bit control word. The configuration is sampled only when a byte is accepted. A pair expansion captures both of its bytes at that moment, so a write made during an expansion cannot split it.

Top module: `tx_match_filter`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1. Every configuration register is cleared, so all bytes pass through unchanged.
- R2: A byte that matches no enabled value is presented on `out_data` with `out_valid` high in the cycle after the clock edge that accepts it, with its value unchanged.
- R3: A byte equal to a match value whose enable bit is clear passes unchanged. The control word bits are: bit0 enables match A, bit1 enables match B, bit2 deletes A hits, bit3 deletes B hits, bit4 expands A hits into a pair.
- R4: A byte that hits enabled match A, with bit2 and bit4 both clear, passes unchanged.
- R5: With bit2 set, a byte hitting match A is deleted and produces no output.
- R6: With bit3 set, a byte hitting match B is deleted and produces no output.
- R7: With bit3 clear, a byte hitting match B is sent as the single substitute byte.
- R8: With bit4 set and bit2 clear, a byte hitting match A is sent as the first pair byte and then the second pair byte. `in_ready` stays low from the accepting edge until the second pair byte has been loaded into the output register.
- R9: Deletion takes priority over expansion when bit2 and bit4 are both set.
- R10: Match A is evaluated first. A byte equal to both enabled match values is handled only by the settings for A.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` stay unchanged. No byte is lost or duplicated under any backpressure pattern.
- R12: A configuration write made during a pair expansion does not change the pair bytes already in flight. The next byte accepted after a write uses the new settings. Register addresses: 0 control word, 1 match A, 2 match B, 3 first pair byte, 4 second pair byte, 5 substitute byte.
- R13: Writes to addresses 6 and 7 have no effect on the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Filter can accept a byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_ready | input | 1 | Downstream accepts the output byte |

## Verification
A configuration write lands on one edge and governs a byte accepted on any later edge. An accepted byte, or the first byte of a pair, is due on the output one cycle after its accepting edge. The second pair byte is due one cycle after the edge that consumes the first pair byte. A deleted byte leaves `out_valid` low in that cycle. The bench keeps a behavioural model that advances on the same edges. It compares `in_ready`, `out_valid` and `out_data` at every falling edge, where all of these are settled. It also collects every consumed output byte and compares each test's stream against the expected byte list.

// File: rtl/tmf_pkg.sv
package tmf_pkg;

    localparam int BYTE_W    = 8;
    localparam int CFG_AW    = 3;

    // configuration register addresses
    localparam logic [CFG_AW-1:0] ADR_CTRL  = 3'd0;
    localparam logic [CFG_AW-1:0] ADR_MATA  = 3'd1;
    localparam logic [CFG_AW-1:0] ADR_MATB  = 3'd2;
    localparam logic [CFG_AW-1:0] ADR_PAIR0 = 3'd3;
    localparam logic [CFG_AW-1:0] ADR_PAIR1 = 3'd4;
    localparam logic [CFG_AW-1:0] ADR_SUBB  = 3'd5;

    // control word bit positions
    localparam int CB_EN_A  = 0;
    localparam int CB_EN_B  = 1;
    localparam int CB_DEL_A = 2;
    localparam int CB_DEL_B = 3;
    localparam int CB_PAIR  = 4;
    localparam int CTRL_W   = 5;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        logic  en_a;
        logic  en_b;
        logic  del_a;
        logic  del_b;
        logic  pair_a;
        byte_t mat_a;
        byte_t mat_b;
        byte_t pair0;
        byte_t pair1;
        byte_t sub_b;
    } flt_cfg_t;

    typedef enum logic [1:0] {
        ACT_PASS = 2'd0,
        ACT_DROP = 2'd1,
        ACT_SUB  = 2'd2,
        ACT_PAIR = 2'd3
    } flt_act_t;

    // match A is consulted first; deletion outranks expansion
    function automatic flt_act_t pick_action(input byte_t b, input flt_cfg_t c);
        flt_act_t a;
        if (c.en_a && (b == c.mat_a)) begin
            if (c.del_a)       a = ACT_DROP;
            else if (c.pair_a) a = ACT_PAIR;
            else               a = ACT_PASS;
        end else if (c.en_b && (b == c.mat_b)) begin
            if (c.del_b) a = ACT_DROP;
            else         a = ACT_SUB;
        end else begin
            a = ACT_PASS;
        end
        return a;
    endfunction

endpackage

// File: rtl/tmf_cfg_regs.sv
module tmf_cfg_regs
    import tmf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [CFG_AW-1:0] addr,
    input  byte_t             wdata,
    output flt_cfg_t          cfg
);

    logic [CTRL_W-1:0] ctrl_q;
    byte_t             mat_a_q, mat_b_q, pair0_q, pair1_q, sub_b_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            mat_a_q <= '0;
            mat_b_q <= '0;
            pair0_q <= '0;
            pair1_q <= '0;
            sub_b_q <= '0;
        end else if (we) begin
            unique case (addr)
                ADR_CTRL:  ctrl_q  <= wdata[CTRL_W-1:0];
                ADR_MATA:  mat_a_q <= wdata;
                ADR_MATB:  mat_b_q <= wdata;
                ADR_PAIR0: pair0_q <= wdata;
                ADR_PAIR1: pair1_q <= wdata;
                ADR_SUBB:  sub_b_q <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        cfg.en_a   = ctrl_q[CB_EN_A];
        cfg.en_b   = ctrl_q[CB_EN_B];
        cfg.del_a  = ctrl_q[CB_DEL_A];
        cfg.del_b  = ctrl_q[CB_DEL_B];
        cfg.pair_a = ctrl_q[CB_PAIR];
        cfg.mat_a  = mat_a_q;
        cfg.mat_b  = mat_b_q;
        cfg.pair0  = pair0_q;
        cfg.pair1  = pair1_q;
        cfg.sub_b  = sub_b_q;
    end

endmodule

// File: rtl/tmf_classify.sv
module tmf_classify
    import tmf_pkg::*;
(
    input  byte_t    in_byte,
    input  flt_cfg_t cfg,
    output flt_act_t act,
    output byte_t    first_byte,
    output byte_t    second_byte
);

    always_comb begin
        act         = pick_action(in_byte, cfg);
        second_byte = cfg.pair1;
        unique case (act)
            ACT_SUB:  first_byte = cfg.sub_b;
            ACT_PAIR: first_byte = cfg.pair0;
            default:  first_byte = in_byte;
        endcase
    end

endmodule

// File: rtl/tmf_out_stage.sv
module tmf_out_stage
    import tmf_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     in_valid,
    input  flt_act_t act,
    input  byte_t    first_byte,
    input  byte_t    second_byte,
    output logic     in_ready,
    output logic     out_valid,
    output byte_t    out_data,
    input  logic     out_ready
);

    logic  pend_q;
    byte_t sec_q;
    logic  slot_free, take, consume;

    assign consume   = out_valid && out_ready;
    assign slot_free = !out_valid || out_ready;
    assign in_ready  = !pend_q && slot_free;
    assign take      = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            pend_q    <= 1'b0;
            sec_q     <= '0;
        end else if (pend_q && out_ready) begin
            out_data <= sec_q;
            pend_q   <= 1'b0;
        end else if (take) begin
            unique case (act)
                ACT_DROP: out_valid <= 1'b0;
                ACT_PAIR: begin
                    out_valid <= 1'b1;
                    out_data  <= first_byte;
                    sec_q     <= second_byte;
                    pend_q    <= 1'b1;
                end
                default: begin
                    out_valid <= 1'b1;
                    out_data  <= first_byte;
                end
            endcase
        end else if (consume) begin
            out_valid <= 1'b0;
        end
    end

    AST_STALL_DURING_PAIR: assert property (@(posedge clk) disable iff (rst)
        pend_q |-> !in_ready) else $error("stall"); // R8
    AST_SECOND_PRESENTED: assert property (@(posedge clk) disable iff (rst)
        $fell(pend_q) |-> out_valid) else $error("second"); // R8
    AST_PAIR_BYTE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (pend_q && $past(pend_q)) |-> $stable(sec_q)) else $error("frozen"); // R12
    AST_HOLD_UNDER_BACKPRESSURE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))) else $error("hold"); // R11
    AST_DROP_NO_OUTPUT: assert property (@(posedge clk) disable iff (rst)
        (take && act == ACT_DROP) |=> !out_valid) else $error("drop"); // R5

endmodule

// File: rtl/tx_match_filter.sv
module tx_match_filter
    import tmf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [BYTE_W-1:0] cfg_wdata,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    input  logic              out_ready
);

    flt_cfg_t cfg;
    flt_act_t act;
    byte_t    first_byte, second_byte;

    tmf_cfg_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    tmf_classify u_cls (
        .in_byte     (in_data),
        .cfg         (cfg),
        .act         (act),
        .first_byte  (first_byte),
        .second_byte (second_byte)
    );

    tmf_out_stage u_out (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .act         (act),
        .first_byte  (first_byte),
        .second_byte (second_byte),
        .in_ready    (in_ready),
        .out_valid   (out_valid),
        .out_data    (out_data),
        .out_ready   (out_ready)
    );

    AST_DISABLED_PASSES: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !cfg.en_a && !cfg.en_b)
        |=> (out_valid && out_data == $past(in_data))) else $error("pass"); // R3

endmodule

// File: tb/sim_tx_match_filter.sv
module sim_tx_match_filter;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_ready;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_ready;

    always #5 clk = ~clk;

    tx_match_filter u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
        .out_ready(out_ready)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    int    cyc   = 0;
    string cur_req = "R1";
    int    ready_mode = 1;   // 0 stall, 1 always, 2 pseudo-random
    logic [15:0] lfsr = 16'hACE1;
    int    got[$];
    int    exp_q[$];

    // behavioural reference state
    int m_cfg[8];
    int m_ov, m_od, m_pend, m_sec;

    task automatic chk(input string req, input int act_v, input int exp_v);
        n_vec++;
        if (act_v != exp_v) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
        end
    endtask

    // 0 pass, 1 delete, 2 substitute, 3 pair
    function automatic int ref_kind(input int b);
        int c = m_cfg[0];
        if ((c & 1) != 0 && b == m_cfg[1]) begin
            if ((c & 4) != 0) return 1;
            if ((c & 16) != 0) return 3;
            return 0;
        end
        if ((c & 2) != 0 && b == m_cfg[2]) begin
            if ((c & 8) != 0) return 1;
            return 2;
        end
        return 0;
    endfunction

    task automatic expect_byte(input int b);
        int k = ref_kind(b);
        if (k == 0) exp_q.push_back(b);
        else if (k == 2) exp_q.push_back(m_cfg[5]);
        else if (k == 3) begin
            exp_q.push_back(m_cfg[3]);
            exp_q.push_back(m_cfg[4]);
        end
    endtask

    function automatic int m_rdy();
        return (m_pend == 0 && (m_ov == 0 || out_ready)) ? 1 : 0;
    endfunction

    // output ready driver
    always @(posedge clk) begin
        #2;
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready <= (ready_mode == 1) ? 1'b1 :
                     (ready_mode == 0) ? 1'b0 : lfsr[3];
    end
    initial out_ready = 1'b1;

    // reference model advances on the same edges
    always @(posedge clk) begin
        if (rst) begin
            m_ov = 0; m_od = 0; m_pend = 0; m_sec = 0;
            foreach (m_cfg[i]) m_cfg[i] = 0;
        end else begin
            int rdy, cons, k;
            rdy  = m_rdy();
            cons = (m_ov != 0 && out_ready) ? 1 : 0;
            if (m_pend != 0 && out_ready) begin
                m_od = m_sec; m_pend = 0;
            end else if (in_valid && rdy != 0) begin
                k = ref_kind(int'(in_data));
                case (k)
                    1: m_ov = 0;
                    2: begin m_ov = 1; m_od = m_cfg[5]; end
                    3: begin m_ov = 1; m_od = m_cfg[3]; m_sec = m_cfg[4]; m_pend = 1; end
                    default: begin m_ov = 1; m_od = int'(in_data); end
                endcase
            end else if (cons != 0) begin
                m_ov = 0;
            end
            if (cfg_we && cfg_addr < 3'd6) begin
                if (cfg_addr == 3'd0) m_cfg[0] = int'(cfg_wdata) & 31;
                else m_cfg[cfg_addr] = int'(cfg_wdata);
            end
        end
    end

    // per-cycle comparison and stream capture, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            chk({cur_req, " in_ready"}, int'(in_ready), m_rdy());
            chk({cur_req, " out_valid"}, int'(out_valid), m_ov);
            if (out_valid && m_ov != 0) chk({cur_req, " out_data"}, int'(out_data), m_od);
            if (out_valid && out_ready) got.push_back(int'(out_data));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_bad++;
            $display("FAIL watchdog %s actual=hung expected=done", cur_req);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic wcfg(input int a, input int d);
        @(posedge clk); #2;
        cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 8'(d);
        @(posedge clk); #2;
        cfg_we = 1'b0;
    endtask

    task automatic push(input int b);
        expect_byte(b);
        @(posedge clk); #2;
        in_valid = 1'b1; in_data = 8'(b);
        forever begin
            @(negedge clk);
            if (in_ready) break;
        end
        @(posedge clk); #2;
        in_valid = 1'b0;
    endtask

    task automatic drain_and_check(input string req);
        ready_mode = 1;
        repeat (8) @(posedge clk);
        chk({req, " stream length"}, got.size(), exp_q.size());
        for (int i = 0; i < got.size() && i < exp_q.size(); i++)
            chk({req, " stream byte"}, got[i], exp_q[i]);
        got.delete();
        exp_q.delete();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        cur_req = "R1";
        chk("R1 out_valid after reset", int'(out_valid), 0);
        chk("R1 in_ready after reset", int'(in_ready), 1);
        push(8'h00);
        drain_and_check("R1");

        cur_req = "R2";
        push(8'h11); push(8'h22); push(8'h33);
        @(negedge clk);
        drain_and_check("R2");

        cur_req = "R3";
        wcfg(1, 8'h41); wcfg(2, 8'h7E);
        wcfg(0, 8'h1C);               // actions set, both enables clear
        push(8'h41); push(8'h7E);
        drain_and_check("R3");

        cur_req = "R4";
        wcfg(0, 8'h01);
        push(8'h41); push(8'h42);
        drain_and_check("R4");

        cur_req = "R5";
        wcfg(0, 8'h05);
        push(8'h40); push(8'h41); push(8'h42);
        drain_and_check("R5");

        cur_req = "R6";
        wcfg(0, 8'h0A);
        push(8'h7E); push(8'h7D);
        drain_and_check("R6");

        cur_req = "R7";
        wcfg(5, 8'h5A); wcfg(0, 8'h02);
        push(8'h7E); push(8'h10);
        drain_and_check("R7");

        cur_req = "R8";
        wcfg(3, 8'hAA); wcfg(4, 8'hBB); wcfg(0, 8'h11);
        ready_mode = 0;
        @(posedge clk); #3;
        push(8'h41);
        @(negedge clk);
        chk("R8 in_ready low during pair", int'(in_ready), 0);
        chk("R8 first pair byte", int'(out_data), 8'hAA);
        drain_and_check("R8");

        cur_req = "R9";
        wcfg(0, 8'h15);
        push(8'h41); push(8'h01);
        drain_and_check("R9");

        cur_req = "R10";
        wcfg(2, 8'h41); wcfg(0, 8'h13);
        push(8'h41);
        drain_and_check("R10");

        cur_req = "R11";
        wcfg(2, 8'h7E); wcfg(0, 8'h13);
        ready_mode = 2;
        for (int i = 0; i < 40; i++) begin
            int b;
            b = (i % 5 == 0) ? 8'h41 : (i % 7 == 0) ? 8'h7E : (i * 13) & 8'hFF;
            push(b);
        end
        drain_and_check("R11");

        cur_req = "R12";
        wcfg(0, 8'h11);
        ready_mode = 0;
        @(posedge clk); #3;
        push(8'h41);
        wcfg(4, 8'hCC);
        wcfg(0, 8'h00);
        exp_q.delete();
        exp_q.push_back(8'hAA); exp_q.push_back(8'hBB);
        ready_mode = 1;
        push(8'h41);
        drain_and_check("R12");

        cur_req = "R13";
        wcfg(0, 8'h05);
        wcfg(6, 8'hFF); wcfg(7, 8'h00);
        push(8'h41); push(8'h55);
        drain_and_check("R13");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule